// File: doc/BRIEF.md
# Transmit Inter-Frame Spacing and Deferral Timer

This block decides when a MAC transmitter is allowed to begin a new frame. It measures time in nibble periods, advancing only on cycles where a nibble-rate enable is high, and it starts measuring either from the end of the local transmission or from the moment sensed carrier drops. A registered grant is raised once a transmit request is pending and the required spacing has fully elapsed.

After a local transmission ends, the spacing is a programmed 7-bit value plus a fixed offset: 3 nibble times when running full duplex and 6 when running half duplex. In half duplex, carrier from other stations puts the timer into a two-stage wait. During the first stage, any carrier restarts the wait. During the second stage, carrier is disregarded. In full duplex, carrier has no effect at all. A mode input selects what a half-duplex request does while it waits: either it waits without limit, or it is dropped with a one-cycle abort pulse after an excessive-deferral limit.

Top module: `ipg_defer_timer`

## Requirements
- R1: While `rst` is high, `tx_grant` and `defer_abort` are 0. After reset the medium counts as idle, so a pending `tx_req` is granted one clock after `rst` falls.
- R2: In full duplex (`full_duplex`=1), a cycle with `tx_end`=1 is followed by a gap of `b2b_gap`+3 enabled nibble cycles. `tx_grant` rises one clock after the last of these cycles.
- R3: In half duplex with carrier low, the gap after `tx_end` is `b2b_gap`+6 enabled nibble cycles. The grant again follows one clock later.
- R4: `tx_grant` is 1 only when `tx_req` was high in the previous cycle while the gap had expired. With the gap expired, raising `tx_req` yields a grant one clock later.
- R5: The gap count advances only on cycles where `nib_en`=1. A `tx_end` pulse at any point restarts the back-to-back gap from zero.
- R6: In half duplex, once carrier falls, the first stage lasts `nb_gap_hi` nibble cycles, and carrier during this stage restarts it. The second stage then lasts `nb_gap_lo` nibble cycles, and carrier during this stage is ignored. A zero stage value behaves as one nibble cycle.
- R7: In full duplex, `carrier` has no effect on the gap or on the grant.
- R8: In half duplex with `defer_wait`=1, a request blocked by carrier never produces `defer_abort`.
- R9: In half duplex with `defer_wait`=0, a request that stays pending and ungranted for `DEFER_LIMIT` (default 6072) enabled nibble cycles produces a one-clock `defer_abort` pulse. The pulse is registered at the clock edge that completes the last nibble, and the deferral count then restarts. `defer_abort` and `tx_grant` are never 1 together.
- R10: `tx_end` takes priority over carrier. When both are high in the same cycle, the back-to-back gap is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_en | input | 1 | One-cycle strobe per nibble time |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| b2b_gap | input | 7 | Back-to-back gap value, offset added internally |
| nb_gap_lo | input | 7 | Second-stage (carrier-ignored) gap in nibbles |
| nb_gap_hi | input | 7 | First-stage (carrier-restartable) gap in nibbles |
| defer_wait | input | 1 | 1 = wait indefinitely, 0 = abort at deferral limit |
| carrier | input | 1 | Carrier sense from the medium |
| tx_req | input | 1 | Transmit request pending |
| tx_end | input | 1 | Pulse marking end of local transmission |
| tx_grant | output | 1 | Registered permission to start a frame |
| defer_abort | output | 1 | One-cycle pulse at excessive deferral |

## Verification
The assertions check several properties on every cycle. The gap is always closed in the cycle after a transmit end. Full duplex never enters the carrier-restart stage, and the carrier-ignored stage can only leave to the idle or back-to-back state. An abort only arises in half duplex with limited deferral, lasts a single clock and never coincides with a grant. Only the directed scenarios can show the exact nibble counts. These cover the 3 and 6 offsets, the two-stage carrier timing with a restart, the gated-enable hold, the exact cycle of the abort at the deferral limit, and the priority of transmit end over carrier.

// File: rtl/ipg_defer_pkg.sv
package ipg_defer_pkg;
  typedef enum logic [1:0] {
    GAP_OPEN  = 2'd0,
    GAP_B2B   = 2'd1,
    GAP_NB_HI = 2'd2,
    GAP_NB_LO = 2'd3
  } gap_state_t;
endpackage

// File: rtl/ipg_gap_fsm.sv
module ipg_gap_fsm
  import ipg_defer_pkg::*;
#(
  parameter int GAP_W  = 7,
  parameter int FD_OFS = 3,
  parameter int HD_OFS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nib_en,
  input  logic             full_duplex,
  input  logic [GAP_W-1:0] b2b_gap,
  input  logic [GAP_W-1:0] nb_gap_lo,
  input  logic [GAP_W-1:0] nb_gap_hi,
  input  logic             carrier,
  input  logic             tx_end,
  output logic             gap_open
);
  localparam int CW = GAP_W + 1;

  gap_state_t    st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] len;

  always_comb begin
    case (st)
      GAP_B2B:   len = {1'b0, b2b_gap} + (full_duplex ? CW'(FD_OFS) : CW'(HD_OFS));
      GAP_NB_HI: len = {1'b0, nb_gap_hi};
      GAP_NB_LO: len = {1'b0, nb_gap_lo};
      default:   len = '0;
    endcase
  end

  assign cnt_inc  = cnt + CW'(1);
  assign gap_open = (st == GAP_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= GAP_OPEN;
      cnt <= '0;
    end else if (tx_end) begin
      st  <= GAP_B2B;
      cnt <= '0;
    end else if (!full_duplex && carrier && st != GAP_NB_LO) begin
      st  <= GAP_NB_HI;
      cnt <= '0;
    end else if (nib_en && st != GAP_OPEN) begin
      if (cnt_inc >= len) begin
        cnt <= '0;
        case (st)
          GAP_NB_HI: st <= GAP_NB_LO;
          default:   st <= GAP_OPEN;
        endcase
      end else begin
        cnt <= cnt_inc;
      end
    end
  end

  // R5: a transmit end always closes the gap on the next cycle
  p_end_closes_r5: assert property (@(posedge clk) disable iff (rst)
    $past(tx_end) |-> !gap_open);

  // R7: full duplex never enters the carrier-restart stage
  p_fd_no_defer_r7: assert property (@(posedge clk) disable iff (rst)
    (full_duplex && $past(full_duplex) && $past(st) != GAP_NB_HI) |-> st != GAP_NB_HI);

  // R6: second stage leaves only to idle or back-to-back, never back to stage one
  p_lo_ignores_carrier_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == GAP_NB_LO) |-> (st == GAP_NB_LO || st == GAP_OPEN || st == GAP_B2B));

  // R2: the counter stays below the longest possible gap
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'((1 << GAP_W) + HD_OFS));
endmodule

// File: rtl/ipg_defer_guard.sv
module ipg_defer_guard #(
  parameter int DEFER_LIMIT = 6072
) (
  input  logic clk,
  input  logic rst,
  input  logic nib_en,
  input  logic full_duplex,
  input  logic defer_wait,
  input  logic tx_req,
  input  logic gap_open,
  output logic defer_abort
);
  localparam int DW = $clog2(DEFER_LIMIT + 1);

  logic [DW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt        <= '0;
      defer_abort <= 1'b0;
    end else begin
      defer_abort <= 1'b0;
      if (!tx_req || gap_open || full_duplex || defer_wait) begin
        dcnt <= '0;
      end else if (nib_en) begin
        if (dcnt == DW'(DEFER_LIMIT - 1)) begin
          dcnt        <= '0;
          defer_abort <= 1'b1;
        end else begin
          dcnt <= dcnt + DW'(1);
        end
      end
    end
  end

  // R8 / R9: abort only with limited deferral in half duplex
  p_abort_mode_r9: assert property (@(posedge clk) disable iff (rst)
    defer_abort |-> $past(!defer_wait && !full_duplex && tx_req));

  // R9: abort is a single-cycle pulse
  p_abort_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    defer_abort |=> !defer_abort);
endmodule

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer #(
  parameter int GAP_W       = 7,
  parameter int DEFER_LIMIT = 6072
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nib_en,
  input  logic             full_duplex,
  input  logic [GAP_W-1:0] b2b_gap,
  input  logic [GAP_W-1:0] nb_gap_lo,
  input  logic [GAP_W-1:0] nb_gap_hi,
  input  logic             defer_wait,
  input  logic             carrier,
  input  logic             tx_req,
  input  logic             tx_end,
  output logic             tx_grant,
  output logic             defer_abort
);
  logic gap_open;

  ipg_gap_fsm #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .nib_en(nib_en), .full_duplex(full_duplex),
    .b2b_gap(b2b_gap), .nb_gap_lo(nb_gap_lo), .nb_gap_hi(nb_gap_hi),
    .carrier(carrier), .tx_end(tx_end), .gap_open(gap_open)
  );

  ipg_defer_guard #(.DEFER_LIMIT(DEFER_LIMIT)) u_defer (
    .clk(clk), .rst(rst), .nib_en(nib_en), .full_duplex(full_duplex),
    .defer_wait(defer_wait), .tx_req(tx_req), .gap_open(gap_open),
    .defer_abort(defer_abort)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_grant <= 1'b0;
    else     tx_grant <= gap_open && tx_req;
  end

  // R9: grant and abort are exclusive
  p_grant_abort_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(tx_grant && defer_abort));

  // R4: no grant without a request in the previous cycle
  p_grant_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> $past(tx_req));
endmodule

// File: tb/sim_ipg_defer_timer.sv
module sim_ipg_defer_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nib_en = 1'b1;
  logic       full_duplex = 1'b1;
  logic [6:0] b2b_gap = 7'h15;
  logic [6:0] nb_gap_lo = 7'h12;
  logic [6:0] nb_gap_hi = 7'h0C;
  logic       defer_wait = 1'b1;
  logic       carrier = 1'b0;
  logic       tx_req = 1'b0;
  logic       tx_end = 1'b0;
  logic       tx_grant;
  logic       defer_abort;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  ipg_defer_timer u0 (
    .clk(clk), .rst(rst), .nib_en(nib_en), .full_duplex(full_duplex),
    .b2b_gap(b2b_gap), .nb_gap_lo(nb_gap_lo), .nb_gap_hi(nb_gap_hi),
    .defer_wait(defer_wait), .carrier(carrier), .tx_req(tx_req),
    .tx_end(tx_end), .tx_grant(tx_grant), .defer_abort(defer_abort)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic end_pulse();
    tx_end = 1'b1;
    cyc(1);
    tx_end = 1'b0;
  endtask

  // grant must be low after g edges and high after g+1
  task automatic expect_grant_at(input string req, input int g);
    cyc(g);
    check(req, tx_grant, 1'b0);
    cyc(1);
    check(req, tx_grant, 1'b1);
  endtask

  task automatic t_reset();
    tx_req = 1'b1;
    cyc(2);
    check("R1", tx_grant, 1'b0);
    check("R1", defer_abort, 1'b0);
    rst = 1'b0;
    cyc(1);
    check("R1", tx_grant, 1'b1);
  endtask

  task automatic t_fd_b2b();
    full_duplex = 1'b1;
    b2b_gap = 7'h15;
    end_pulse();
    expect_grant_at("R2", 7'h15 + 3);
    b2b_gap = 7'h00;
    end_pulse();
    expect_grant_at("R2", 3);
    b2b_gap = 7'h7F;
    end_pulse();
    expect_grant_at("R2", 127 + 3);
  endtask

  task automatic t_hd_b2b();
    full_duplex = 1'b0;
    b2b_gap = 7'h12;
    end_pulse();
    expect_grant_at("R3", 7'h12 + 6);
  endtask

  task automatic t_req_gate();
    full_duplex = 1'b1;
    tx_req = 1'b0;
    cyc(3);
    check("R4", tx_grant, 1'b0);
    tx_req = 1'b1;
    cyc(1);
    check("R4", tx_grant, 1'b1);
  endtask

  task automatic t_nib_en();
    full_duplex = 1'b1;
    b2b_gap = 7'h15;
    end_pulse();
    nib_en = 1'b0;
    cyc(60);
    check("R5", tx_grant, 1'b0);
    nib_en = 1'b1;
    cyc(10);
    end_pulse();
    expect_grant_at("R5", 24);
  endtask

  task automatic t_two_stage();
    full_duplex = 1'b0;
    defer_wait = 1'b1;
    nb_gap_hi = 7'h0C;
    nb_gap_lo = 7'h12;
    carrier = 1'b1;
    cyc(3);
    carrier = 1'b0;
    expect_grant_at("R6 plain", 12 + 18);
    carrier = 1'b1;
    cyc(2);
    carrier = 1'b0;
    cyc(5);
    carrier = 1'b1;
    cyc(1);
    carrier = 1'b0;
    expect_grant_at("R6 restart", 30);
    carrier = 1'b1;
    cyc(2);
    carrier = 1'b0;
    cyc(15);
    carrier = 1'b1;
    cyc(1);
    carrier = 1'b0;
    expect_grant_at("R6 ignore", 30 - 16);
  endtask

  task automatic t_fd_carrier();
    full_duplex = 1'b1;
    b2b_gap = 7'h15;
    carrier = 1'b1;
    end_pulse();
    expect_grant_at("R7", 24);
    carrier = 1'b0;
  endtask

  task automatic t_defer();
    full_duplex = 1'b0;
    defer_wait = 1'b1;
    tx_req = 1'b0;
    carrier = 1'b1;
    cyc(2);
    tx_req = 1'b1;
    for (int i = 0; i < 7000; i++) begin
      cyc(1);
      if (defer_abort) check("R8", defer_abort, 1'b0);
    end
    check("R8", defer_abort, 1'b0);
    tx_req = 1'b0;
    defer_wait = 1'b0;
    cyc(2);
    tx_req = 1'b1;
    cyc(6071);
    check("R9", defer_abort, 1'b0);
    cyc(1);
    check("R9", defer_abort, 1'b1);
    check("R9", tx_grant, 1'b0);
    cyc(1);
    check("R9", defer_abort, 1'b0);
    tx_req = 1'b0;
    carrier = 1'b0;
    defer_wait = 1'b1;
    cyc(40);
    tx_req = 1'b1;
  endtask

  task automatic t_priority();
    full_duplex = 1'b0;
    b2b_gap = 7'h12;
    carrier = 1'b1;
    tx_end = 1'b1;
    cyc(1);
    carrier = 1'b0;
    tx_end = 1'b0;
    expect_grant_at("R10", 24);
  endtask

  initial begin
    t_reset();
    t_fd_b2b();
    t_hd_b2b();
    t_req_gate();
    t_nib_en();
    t_two_stage();
    t_fd_carrier();
    t_defer();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule